// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with TLB and Page-Table Walk

This block turns a 14-bit virtual address into a 12-bit physical address for a single requester. A request carries the address and an access kind (load, store or instruction fetch) and is accepted through a valid/ready handshake. The bottom six bits of the address give the byte within a 64-byte page and pass through unchanged. The upper eight bits give the virtual page number, and this number is looked up in a 16-entry, 4-way set-associative translation buffer.

When the buffer holds the page, the response comes back on the next cycle. When it does not, the block reads one page-table entry from a memory port. The address of that read is a page-table base input plus the page number. The port may take any number of cycles to answer. A valid entry is installed in the buffer and the request is completed. Every access is checked against the valid bit and the read, write and execute rights. It then completes with a success code and a physical address, or with a page-fault or protection-fault code. Only one request is in flight at a time. A flush input empties the buffer in a single cycle.

Top module: `mmu_xlate`

## Requirements
- R1: The page number is `req_vaddr[13:6]` and the page offset is `req_vaddr[5:0]`. A successful response gives `rsp_paddr = {PPN, offset}`.
- R2: A request that misses in the buffer raises exactly one memory read at `mem_req_addr = ptbr + page number` (modulo 2^12). `mem_req_valid` and the address stay steady until `mem_req_ready` is seen high at a clock edge.
- R3: A page-table entry word is 11 bits wide. Bits [5:0] hold the PPN, bit 6 the valid flag, bit 7 the dirty flag (not used by this block), bit 8 read, bit 9 write and bit 10 execute.
- R4: An entry with valid = 0 completes with `rsp_status = 1` (page fault) and `rsp_paddr = 0`. Such an entry is never installed, so a repeat access walks again.
- R5: Access code 0 (load) and code 3 need the read right. Code 1 (store) needs the write right and code 2 (fetch) needs the execute right. A missing right gives `rsp_status = 2` (protection fault) with `rsp_paddr = 0`, on a buffer hit and after a walk alike. Success is `rsp_status = 0`.
- R6: A buffer hit raises `rsp_valid` in the cycle right after acceptance and makes no memory request.
- R7: The buffer has 4 sets of 4 ways, indexed by page number bits [1:0] and tagged by bits [7:2]. Four pages that share an index are all held at once, and at most one way matches any lookup.
- R8: In each set the way that is filled advances round-robin on each install. A fifth distinct page in a full set evicts the page that was installed first.
- R9: While `flush` is high, `req_ready` is low and every entry is cleared in that cycle. The next access to any page walks the page table. An install that falls in a flush cycle is dropped.
- R10: `req_ready` is low from the acceptance of a missing request until its response cycle. Each accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R11: After a walk, `rsp_valid` rises in the cycle right after the clock edge at which `mem_rsp_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| ptbr | input | 12 | Page-table base address for the current process |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 14 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 treated as load |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 success, 1 page fault, 2 protection fault |
| rsp_paddr | output | 12 | Physical address, zero on a fault |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 12 | Address of the page-table entry |
| mem_rsp_valid | input | 1 | Page-table entry returned |
| mem_rsp_data | input | 11 | Page-table entry word |

## Verification
A stale or wrongly tagged buffer entry shows up on the very next access to that page. It appears either as a response one cycle after acceptance where a memory read was due, or as a memory read where a hit was due, so every scenario checks `mem_req_valid` and `rsp_valid` in the first cycle after acceptance. A wrong replacement pointer only becomes visible after several installs into one set, and a stuck walker state shows up as `req_ready` staying low. The scenarios therefore fill one set past its capacity and probe each page afterwards, and every transaction ends by checking that the handshake has recovered.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PAGEF = 2'd1,
    ST_PROTF = 2'd2,
    ST_NONE  = 2'd3
  } stat_e;

  // rights vector order: {execute, write, read}
  function automatic logic right_granted(acc_e kind, logic [2:0] rights);
    case (kind)
      ACC_STORE: right_granted = rights[1];
      ACC_FETCH: right_granted = rights[2];
      default:   right_granted = rights[0];
    endcase
  endfunction

endpackage

// File: rtl/mmu_perm.sv
module mmu_perm
  import mmu_pkg::*;
(
  input  logic       page_ok,
  input  logic [1:0] kind,
  input  logic [2:0] rights,
  output logic [1:0] status
);

  always_comb begin
    if (!page_ok)
      status = ST_PAGEF;
    else if (right_granted(acc_e'(kind), rights))
      status = ST_OK;
    else
      status = ST_PROTF;
  end

endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic [WAYS-1:0]  hit_vec,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [2:0]       hit_rights,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [2:0]       fill_rights
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [WAY_W-1:0] WAY_ONE = WAY_W'(1);

  function automatic logic [IDX_W-1:0] idx_of(logic [VPN_W-1:0] v);
    return v[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [VPN_W-1:0] v);
    return v[VPN_W-1:IDX_W];
  endfunction

  logic [WAYS-1:0]  vld     [SETS];
  logic [WAY_W-1:0] rr_q    [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
  logic [2:0]       right_q [SETS][WAYS];

  logic [IDX_W-1:0] li, fi;
  logic [TAG_W-1:0] lt, ft;
  logic             do_fill;

  assign li      = idx_of(lk_vpn);
  assign lt      = tag_of(lk_vpn);
  assign fi      = idx_of(fill_vpn);
  assign ft      = tag_of(fill_vpn);
  assign do_fill = fill_en && !flush;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld[li][w] && (tag_q[li][w] == lt);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_ppn    = '0;
    hit_rights = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_ppn    = hit_ppn | ppn_q[li][w];
        hit_rights = hit_rights | right_q[li][w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        rr_q[s] <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (fill_en) begin
      vld[fi][rr_q[fi]] <= 1'b1;
      rr_q[fi]          <= rr_q[fi] + WAY_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[fi][rr_q[fi]]   <= ft;
      ppn_q[fi][rr_q[fi]]   <= fill_ppn;
      right_q[fi][rr_q[fi]] <= fill_rights;
    end
  end

endmodule

// File: rtl/mmu_walker.sv
module mmu_walker #(
  parameter int VPN_W = 8,
  parameter int PA_W  = 12,
  parameter int PTE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PA_W-1:0]  base,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PTE_W-1:0] pte
);

  typedef enum logic [1:0] {W_IDLE, W_ISSUE, W_WAIT} wstate_e;

  function automatic logic [PA_W-1:0] entry_addr(logic [PA_W-1:0] b, logic [VPN_W-1:0] v);
    return b + {{(PA_W-VPN_W){1'b0}}, v};
  endfunction

  wstate_e          st_q;
  logic [PA_W-1:0]  addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      addr_q <= '0;
    end else begin
      case (st_q)
        W_IDLE:  if (start) begin
                   addr_q <= entry_addr(base, vpn);
                   st_q   <= W_ISSUE;
                 end
        W_ISSUE: if (mem_req_ready) st_q <= W_WAIT;
        W_WAIT:  if (mem_rsp_valid) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy          = (st_q != W_IDLE);
  assign mem_req_valid = (st_q == W_ISSUE);
  assign mem_req_addr  = addr_q;
  assign done          = (st_q == W_WAIT) && mem_rsp_valid;
  assign pte           = mem_rsp_data;

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int VA_W     = 14,
  parameter int PA_W     = 12,
  parameter int OFF_W    = 6,
  parameter int TLB_SETS = 4,
  parameter int TLB_WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PA_W-1:0]   ptbr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PA_W-OFF_W+4:0] mem_rsp_data
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int PTE_W = PPN_W + 5;
  localparam int B_V   = PPN_W;
  localparam int B_R   = PPN_W + 2;
  localparam int B_X   = PPN_W + 4;

  function automatic logic [VPN_W-1:0] page_of(logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(logic [PPN_W-1:0] p, logic [OFF_W-1:0] o);
    return {p, o};
  endfunction

  // named internal events (used by the bound checker)
  logic                tlb_hit;
  logic [TLB_WAYS-1:0] tlb_hit_vec;
  logic [PPN_W-1:0]    tlb_ppn;
  logic [2:0]          tlb_rights;
  logic                walk_busy;
  logic                walk_done;
  logic                walk_start;
  logic [PTE_W-1:0]    walk_pte;
  logic                accept;
  logic                fill_en;

  logic [VPN_W-1:0]    pend_vpn;
  logic [OFF_W-1:0]    pend_off;
  logic [1:0]          pend_acc;

  logic                chk_ok_page;
  logic [1:0]          chk_kind;
  logic [2:0]          chk_rights;
  logic [PPN_W-1:0]    chk_ppn;
  logic [OFF_W-1:0]    chk_off;
  logic [1:0]          chk_status;
  logic                rsp_fire;

  logic                rsp_valid_q;
  logic [1:0]          rsp_status_q;
  logic [PA_W-1:0]     rsp_paddr_q;

  assign req_ready  = !walk_busy && !flush;
  assign accept     = req_valid && req_ready;
  assign walk_start = accept && !tlb_hit;

  mmu_tlb #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(TLB_SETS), .WAYS(TLB_WAYS)
  ) u_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_vpn     (page_of(req_vaddr)),
    .hit_vec    (tlb_hit_vec),
    .hit        (tlb_hit),
    .hit_ppn    (tlb_ppn),
    .hit_rights (tlb_rights),
    .fill_en    (fill_en),
    .fill_vpn   (pend_vpn),
    .fill_ppn   (walk_pte[PPN_W-1:0]),
    .fill_rights(walk_pte[B_X:B_R])
  );

  mmu_walker #(
    .VPN_W(VPN_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (walk_start),
    .vpn          (page_of(req_vaddr)),
    .base         (ptbr),
    .busy         (walk_busy),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .done         (walk_done),
    .pte          (walk_pte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vpn <= '0;
      pend_off <= '0;
      pend_acc <= '0;
    end else if (walk_start) begin
      pend_vpn <= page_of(req_vaddr);
      pend_off <= offset_of(req_vaddr);
      pend_acc <= req_acc;
    end
  end

  assign fill_en = walk_done && walk_pte[B_V];

  always_comb begin
    if (walk_done) begin
      chk_ok_page = walk_pte[B_V];
      chk_kind    = pend_acc;
      chk_rights  = walk_pte[B_X:B_R];
      chk_ppn     = walk_pte[PPN_W-1:0];
      chk_off     = pend_off;
    end else begin
      chk_ok_page = 1'b1;
      chk_kind    = req_acc;
      chk_rights  = tlb_rights;
      chk_ppn     = tlb_ppn;
      chk_off     = offset_of(req_vaddr);
    end
  end

  mmu_perm u_perm (
    .page_ok(chk_ok_page),
    .kind   (chk_kind),
    .rights (chk_rights),
    .status (chk_status)
  );

  assign rsp_fire = (accept && tlb_hit) || walk_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_OK;
      rsp_paddr_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_fire;
      if (rsp_fire) begin
        rsp_status_q <= chk_status;
        rsp_paddr_q  <= (chk_status == ST_OK) ? join_pa(chk_ppn, chk_off) : '0;
      end
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;
  assign rsp_paddr  = rsp_paddr_q;

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
  parameter int PA_W = 12,
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic [1:0]      rsp_status,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            lk_hit,
  input logic [WAYS-1:0] hit_vec,
  input logic            walk_done
);

  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fault_no_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

  assert_hit_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit) |=> (rsp_valid && !mem_req_valid));

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  assert_miss_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !lk_hit) |=> (!req_ready && !rsp_valid));

  assert_walk_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> rsp_valid);

endmodule

bind mmu_xlate mmu_xlate_chk #(.PA_W(PA_W), .WAYS(TLB_WAYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_status   (rsp_status),
  .rsp_paddr    (rsp_paddr),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .lk_hit       (tlb_hit),
  .hit_vec      (tlb_hit_vec),
  .walk_done    (walk_done)
);

// File: tb/test_mmu_xlate.sv
module test_mmu_xlate;

  localparam logic [11:0] BASE = 12'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [11:0] ptbr = BASE;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [11:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [11:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [10:0] mem_rsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [10:0] pt [256];

  always #5 clk = ~clk;

  mmu_xlate i_mmu_xlate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbr(ptbr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // R3 entry layout: {x, w, r, dirty, valid, ppn[5:0]}
  function automatic logic [10:0] pte(logic [5:0] ppn, bit r, bit w, bit x);
    return {x, w, r, 1'b0, 1'b1, ppn};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // one translation; walk selects the expected path
  task automatic xlate(string rq, logic [13:0] va, logic [1:0] acc, bit walk,
                       int rdy_dly, int lat, logic [1:0] exp_st, logic [11:0] exp_pa);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!walk) begin
      chk({rq, " R6 no memory read on hit"}, mem_req_valid, 0);
      chk({rq, " R6 hit reply next cycle"}, rsp_valid, 1);
    end else begin
      chk({rq, " R10 no early reply"}, rsp_valid, 0);
      chk({rq, " R2 read issued"}, mem_req_valid, 1);
      chk({rq, " R2 entry address"}, mem_req_addr, BASE + {4'h0, va[13:6]});
      chk({rq, " R10 busy blocks requests"}, req_ready, 0);
      repeat (rdy_dly) @(negedge clk);
      chk({rq, " R2 read held"}, mem_req_valid, 1);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk({rq, " R2 single read"}, mem_req_valid, 0);
      repeat (lat) @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_data = pt[va[13:6]];
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk({rq, " R11 reply after entry"}, rsp_valid, 1);
    end
    chk({rq, " status"}, rsp_status, exp_st);
    chk({rq, " R1 address"}, rsp_paddr, exp_pa);
    @(negedge clk);
    chk({rq, " R10 single pulse"}, rsp_valid, 0);
    chk({rq, " R10 ready again"}, req_ready, 1);
  endtask

  task automatic t_reset;
    chk("R10 reset ready", req_ready, 1);
    chk("R10 reset no reply", rsp_valid, 0);
    chk("R2 reset no read", mem_req_valid, 0);
  endtask

  task automatic t_walk_then_hit;
    xlate("R1 0x03d4 miss", 14'h03d4, 2'd0, 1, 2, 3, 2'd0, 12'h354);
    xlate("R6 0x03d4 hit",  14'h03d4, 2'd0, 0, 0, 0, 2'd0, 12'h354);
    xlate("R3 0x0020 miss", 14'h0020, 2'd0, 1, 0, 0, 2'd0, 12'ha20);
    xlate("R5 0x0020 store hit", 14'h0020, 2'd1, 0, 0, 0, 2'd0, 12'ha20);
  endtask

  task automatic t_page_fault;
    xlate("R4 invalid entry", 14'h038f, 2'd0, 1, 1, 2, 2'd1, 12'h000);
    xlate("R4 not installed", 14'h038f, 2'd0, 1, 0, 1, 2'd1, 12'h000);
  endtask

  task automatic t_rights;
    xlate("R5 load r-x walk",  14'h036b, 2'd0, 1, 0, 0, 2'd0, 12'hb6b);
    xlate("R5 store r-x hit",  14'h036b, 2'd1, 0, 0, 0, 2'd2, 12'h000);
    xlate("R5 fetch r-x hit",  14'h036b, 2'd2, 0, 0, 0, 2'd0, 12'hb6b);
    xlate("R5 load --x walk",  14'h0845, 2'd0, 1, 0, 4, 2'd2, 12'h000);
    xlate("R5 fetch --x hit",  14'h0845, 2'd2, 0, 0, 0, 2'd0, 12'h445);
    xlate("R5 store --x hit",  14'h0845, 2'd1, 0, 0, 0, 2'd2, 12'h000);
    xlate("R5 code3 --x hit",  14'h0845, 2'd3, 0, 0, 0, 2'd2, 12'h000);
  endtask

  // set 0 already holds page 0x00 in its first way
  task automatic t_round_robin;
    for (int k = 1; k < 4; k++)
      xlate("R7 fill set0", {8'(k * 4), 6'h3f}, 2'd0, 1, 0, 1, 2'd0, {6'(k * 4 + 32), 6'h3f});
    xlate("R7 hold 0x00", 14'h0020, 2'd0, 0, 0, 0, 2'd0, 12'ha20);
    for (int k = 1; k < 4; k++)
      xlate("R7 hold set0", {8'(k * 4), 6'h3f}, 2'd0, 0, 0, 0, 2'd0, {6'(k * 4 + 32), 6'h3f});
    xlate("R8 fifth page", {8'h10, 6'h3f}, 2'd0, 1, 0, 0, 2'd0, {6'h30, 6'h3f});
    xlate("R8 0x04 kept",  {8'h04, 6'h3f}, 2'd0, 0, 0, 0, 2'd0, {6'h24, 6'h3f});
    xlate("R8 0x00 evicted", 14'h0020, 2'd0, 1, 0, 0, 2'd0, 12'ha20);
    xlate("R8 0x08 kept",  {8'h08, 6'h3f}, 2'd0, 0, 0, 0, 2'd0, {6'h28, 6'h3f});
    xlate("R8 0x04 now evicted", {8'h04, 6'h3f}, 2'd0, 1, 0, 0, 2'd0, {6'h24, 6'h3f});
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk("R9 ready low in flush", req_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    xlate("R9 0x03d4 after flush", 14'h03d4, 2'd0, 1, 0, 0, 2'd0, 12'h354);
    xlate("R9 0x036b after flush", 14'h036b, 2'd2, 1, 0, 0, 2'd0, 12'hb6b);
    xlate("R9 0x03d4 refilled",    14'h03d4, 2'd0, 0, 0, 0, 2'd0, 12'h354);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pt[i] = 11'h000;
    pt[8'h0f] = pte(6'h0d, 1, 1, 0);
    pt[8'h00] = pte(6'h28, 1, 1, 0);
    pt[8'h0d] = pte(6'h2d, 1, 0, 1);
    pt[8'h21] = pte(6'h11, 0, 0, 1);
    for (int k = 1; k < 5; k++) pt[k * 4] = pte(6'(k * 4 + 32), 1, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk_then_hit();
    t_page_fault();
    t_rights();
    t_round_robin();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule